// File: doc/BRIEF.md
# Multi-Source GPIO Port with Change Notification

This block is a general-purpose I/O port of sixteen pins. Software configures it through two registers on a simple register port. The first is a 32-bit control word that carries two bits for each pin: one picks output direction and one enables a pull-up. The second is a 16-bit data word holding the value the CPU drives. Each pin's level is merged from three sources: the CPU's output, the outputs of up to four attached peripheral slots, and the pull-up. The pull-up counts only when neither the CPU nor any peripheral drives the pin. Reading the data register returns these merged levels rather than the stored data word.

A change monitor samples the merged levels on every clock and compares each sample with the previous one. When pins change, it presents the set of changed pins for one cycle. It also raises a one-cycle strobe for every peripheral slot whose trigger mask overlaps that set. Changes caused by register writes and changes caused by peripherals are both reported.

The monitor is a two-state machine. `ST_SETTLE` is the single state after reset: it captures the first levels and reports nothing. Its only transition, settle-to-watch, always leads to `ST_WATCH`. `ST_WATCH` compares and reports on every cycle, and its only transition is watch-to-watch.

Top module: `gpio_merge_port`

## Requirements
- R1: After reset the control word reads 0, so every pin is an input with no pull-up. A pin with no peripheral drive then reads 0.
- R2: For pin n, control bit 2n set makes the CPU drive the pin, and control bit 2n+1 set enables its pull-up.
- R3: Each pin level equals (cpu_dir AND cpu_data) OR (any slot's direction AND that slot's data) OR (pull-up AND no source drives the pin).
- R4: With bus_sel = 0 the read port returns the control word. With bus_sel = 1 it returns the merged pin levels in bits 15:0 and zeros above them. A write with bus_sel = 0 loads all 32 bits into the control word; a write with bus_sel = 1 loads bits 15:0 into the data word.
- R5: change_vec is the XOR of the merged levels at two consecutive clock edges. It is presented in the cycle after the new level first shows on pin_level, and it lasts one cycle.
- R6: When no pin changed between two edges, change_vec is 0 and no slot strobe is raised, including after a write that does not alter any level.
- R7: Slot s strobes exactly when the AND of its 16-bit trigger mask (slot_mask bits 16s+15:16s) with the changed-pin set is nonzero.
- R8: Level changes caused only by peripheral drive inputs are reported the same way as changes caused by register writes.
- R9: The first clock edge after reset is in ST_SETTLE: it records the levels and reports no change, whatever the pins are being driven to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_sel | input | 1 | Register select: 0 = control word, 1 = data word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register (combinational) |
| per_out | input | 64 | Peripheral data, 16 bits per slot, slot s at bits 16s+15:16s |
| per_oe | input | 64 | Peripheral direction, 16 bits per slot, same layout as per_out |
| slot_mask | input | 64 | Trigger mask per slot, same layout as per_out |
| pin_level | output | 16 | Merged pin levels |
| change_vec | output | 16 | Pins that changed at the last edge (one-cycle pulse) |
| slot_notify | output | 4 | One-cycle notification strobe per slot |

## Verification
If the stored previous levels are wrong, change_vec and the slot strobes show a spurious or missing pulse at the very next edge. They keep doing so until the stored copy resynchronises one cycle later. A wrong control or data register shows at once on pin_level and on the data read-back. The bench sweeps every combination of CPU direction, CPU data, peripheral direction, peripheral data and pull-up on every pin, so the fault appears within the same sweep step. A state machine stuck in ST_SETTLE holds change_vec at 0 through the first deliberate pin change, and the bench checks that change on the first cycle it becomes visible.

// File: rtl/gpio_merge_pkg.sv
package gpio_merge_pkg;

    // register select encoding on the bus port
    localparam logic SEL_CTRL = 1'b0;
    localparam logic SEL_DATA = 1'b1;

    // change monitor states
    typedef enum logic {
        ST_SETTLE = 1'b0,
        ST_WATCH  = 1'b1
    } mon_state_e;

endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_merge_pkg::*;
#(
    parameter int PINS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              sel,
    input  logic [2*PINS-1:0] wdata,
    output logic [2*PINS-1:0] ctrl_q,
    output logic [PINS-1:0]   data_q
);
    localparam int CTRL_W = 2 * PINS;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            data_q <= '0;
        end else if (wr_en) begin
            if (sel == SEL_CTRL) begin
                ctrl_q <= wdata;
            end else begin
                data_q <= wdata[PINS-1:0];
            end
        end
    end

    // R4: a control write lands in full on the next edge
    assert_ctrl_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_CTRL) |=> (ctrl_q == $past(wdata)));

    // R4: a data write leaves the control word alone
    assert_ctrl_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_DATA) |=> $stable(ctrl_q));

    // R4: the data word only moves on a data write
    assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && sel == SEL_DATA) |=> $stable(data_q));

    localparam int UNUSED_W = CTRL_W;
endmodule

// File: rtl/gpio_pin_resolve.sv
module gpio_pin_resolve #(
    parameter int PINS  = 16,
    parameter int SLOTS = 4
) (
    input  logic [2*PINS-1:0]     ctrl,
    input  logic [PINS-1:0]       cpu_data,
    input  logic [SLOTS*PINS-1:0] per_out,
    input  logic [SLOTS*PINS-1:0] per_oe,
    output logic [PINS-1:0]       level
);
    logic [PINS-1:0] cpu_dir;
    logic [PINS-1:0] pull_en;
    logic [PINS-1:0] per_dir_any;
    logic [PINS-1:0] per_drv_any;

    // de-interleave the control word: even bit = direction, odd bit = pull-up
    for (genvar n = 0; n < PINS; n++) begin : g_unpack
        assign cpu_dir[n] = ctrl[2*n];
        assign pull_en[n] = ctrl[2*n+1];
    end

    // fold the peripheral slots into one drive and one enable vector
    always_comb begin
        per_dir_any = '0;
        per_drv_any = '0;
        for (int s = 0; s < SLOTS; s++) begin
            per_dir_any = per_dir_any | per_oe[s*PINS +: PINS];
            per_drv_any = per_drv_any | (per_oe[s*PINS +: PINS] & per_out[s*PINS +: PINS]);
        end
    end

    assign level = (cpu_dir & cpu_data) | per_drv_any | (~(cpu_dir | per_dir_any) & pull_en);

    // R3: a pin nobody drives follows its pull-up bit
    always_comb begin
        for (int n = 0; n < PINS; n++) begin
            if (!ctrl[2*n] && !per_dir_any[n]) begin
                assert_float_follows_pull_R3: assert (level[n] == ctrl[2*n+1]);
            end
        end
    end

    // R2: a pin the CPU drives high reads high regardless of the pull-up
    always_comb begin
        for (int n = 0; n < PINS; n++) begin
            if (ctrl[2*n] && cpu_data[n]) begin
                assert_cpu_high_wins_R2: assert (level[n]);
            end
        end
    end
endmodule

// File: rtl/gpio_change_detect.sv
module gpio_change_detect
    import gpio_merge_pkg::*;
#(
    parameter int PINS  = 16,
    parameter int SLOTS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PINS-1:0]       level,
    input  logic [SLOTS*PINS-1:0] slot_mask,
    output logic [PINS-1:0]       change_vec,
    output logic [SLOTS-1:0]      slot_notify
);
    mon_state_e      state;
    mon_state_e      state_nxt;
    logic [PINS-1:0] lvl_q;
    logic [PINS-1:0] diff;
    logic [SLOTS-1:0] hit;

    assign diff = level ^ lvl_q;

    for (genvar s = 0; s < SLOTS; s++) begin : g_hit
        assign hit[s] = |(slot_mask[s*PINS +: PINS] & diff);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_SETTLE;
        end else begin
            state <= state_nxt;
        end
    end

    // transitions: settle-to-watch, watch-to-watch
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_SETTLE: state_nxt = ST_WATCH;
            ST_WATCH:  state_nxt = ST_WATCH;
            default:   state_nxt = ST_SETTLE;
        endcase
    end

    // outputs and level history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q       <= '0;
            change_vec  <= '0;
            slot_notify <= '0;
        end else begin
            lvl_q <= level;
            unique case (state)
                ST_SETTLE: begin
                    change_vec  <= '0;
                    slot_notify <= '0;
                end
                ST_WATCH: begin
                    change_vec  <= diff;
                    slot_notify <= hit;
                end
                default: begin
                    change_vec  <= '0;
                    slot_notify <= '0;
                end
            endcase
        end
    end

    // R6: no strobe without a changed pin
    assert_quiet_when_still_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (change_vec == '0) |-> (slot_notify == '0));

    // R5: the reported set is the difference of two successive samples
    assert_diff_history_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WATCH && $past(state) == ST_WATCH) |-> (change_vec == ($past(lvl_q) ^ lvl_q)));

    // R9: the settle edge reports nothing
    assert_settle_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WATCH && $past(state) == ST_SETTLE) |-> (change_vec == '0 && slot_notify == '0));

    // R7: a slot strobes only on overlap with its mask
    for (genvar s = 0; s < SLOTS; s++) begin : g_chk
        assert_mask_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
            slot_notify[s] |-> (|($past(slot_mask[s*PINS +: PINS]) & change_vec)));
    end
endmodule

// File: rtl/gpio_merge_port.sv
module gpio_merge_port
    import gpio_merge_pkg::*;
#(
    parameter int PINS  = 16,
    parameter int SLOTS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic                  bus_sel,
    input  logic [2*PINS-1:0]     bus_wdata,
    output logic [2*PINS-1:0]     bus_rdata,
    input  logic [SLOTS*PINS-1:0] per_out,
    input  logic [SLOTS*PINS-1:0] per_oe,
    input  logic [SLOTS*PINS-1:0] slot_mask,
    output logic [PINS-1:0]       pin_level,
    output logic [PINS-1:0]       change_vec,
    output logic [SLOTS-1:0]      slot_notify
);
    localparam int CTRL_W = 2 * PINS;
    localparam int PAD_W  = CTRL_W - PINS;

    logic [CTRL_W-1:0] ctrl_q;
    logic [PINS-1:0]   data_q;

    gpio_cfg_regs #(.PINS(PINS)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_wr),
        .sel    (bus_sel),
        .wdata  (bus_wdata),
        .ctrl_q (ctrl_q),
        .data_q (data_q)
    );

    gpio_pin_resolve #(.PINS(PINS), .SLOTS(SLOTS)) u_resolve (
        .ctrl     (ctrl_q),
        .cpu_data (data_q),
        .per_out  (per_out),
        .per_oe   (per_oe),
        .level    (pin_level)
    );

    gpio_change_detect #(.PINS(PINS), .SLOTS(SLOTS)) u_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .level       (pin_level),
        .slot_mask   (slot_mask),
        .change_vec  (change_vec),
        .slot_notify (slot_notify)
    );

    // data read returns merged levels, never the stored data word
    always_comb begin
        if (bus_sel == SEL_DATA) begin
            bus_rdata = {{PAD_W{1'b0}}, pin_level};
        end else begin
            bus_rdata = ctrl_q;
        end
    end

    // R1: the edge after reset leaves the control word cleared
    assert_reset_ctrl_R1: assert property (@(posedge clk)
        $past(!rst_n) && rst_n && !(bus_sel == SEL_CTRL && bus_wr) |-> (ctrl_q == '0));
endmodule

// File: tb/gpio_merge_port_tb.sv
module gpio_merge_port_tb;
    localparam int PINS  = 16;
    localparam int SLOTS = 4;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  bus_wr = 1'b0;
    logic                  bus_sel = 1'b0;
    logic [2*PINS-1:0]     bus_wdata = '0;
    logic [2*PINS-1:0]     bus_rdata;
    logic [SLOTS*PINS-1:0] per_out = '0;
    logic [SLOTS*PINS-1:0] per_oe = '0;
    logic [SLOTS*PINS-1:0] slot_mask = '0;
    logic [PINS-1:0]       pin_level;
    logic [PINS-1:0]       change_vec;
    logic [SLOTS-1:0]      slot_notify;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_merge_port #(.PINS(PINS), .SLOTS(SLOTS)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .per_out(per_out),
        .per_oe(per_oe), .slot_mask(slot_mask), .pin_level(pin_level),
        .change_vec(change_vec), .slot_notify(slot_notify)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] model(input logic [31:0] c, input logic [15:0] d,
                                          input logic [63:0] po, input logic [63:0] pe);
        logic [15:0] r;
        for (int n = 0; n < 16; n++) begin
            logic cd, pu, pd, pv;
            cd = c[2*n];
            pu = c[2*n+1];
            pd = 1'b0;
            pv = 1'b0;
            for (int s = 0; s < 4; s++) begin
                pd = pd | pe[16*s+n];
                pv = pv | (pe[16*s+n] & po[16*s+n]);
            end
            r[n] = (cd & d[n]) | pv | (!(cd | pd) & pu);
        end
        return r;
    endfunction

    function automatic logic [3:0] hits(input logic [63:0] m, input logic [15:0] chg);
        logic [3:0] h;
        for (int s = 0; s < 4; s++) h[s] = |(m[16*s +: 16] & chg);
        return h;
    endfunction

    task automatic wr(input logic sel, input logic [31:0] val);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_sel = sel;
        bus_wdata = val;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    // after a level change became visible: next edge reports it, the one after is quiet
    task automatic expect_change(input string tag, input logic [15:0] prev, input logic [15:0] now);
        @(posedge clk);
        #1;
        check({tag, " change_vec"}, {16'h0, change_vec}, {16'h0, prev ^ now});
        check({tag, " slot_notify"}, {28'h0, slot_notify}, {28'h0, hits(slot_mask, prev ^ now)});
        @(posedge clk);
        #1;
        check("R6 quiet change_vec", {16'h0, change_vec}, 32'h0);
        check("R6 quiet slot_notify", {28'h0, slot_notify}, 32'h0);
    endtask

    initial begin
        logic [31:0] cw;
        logic [15:0] dw;
        logic [15:0] prev;
        logic [15:0] exp;

        slot_mask = {16'h0000, 16'h0101, 16'hF000, 16'h000F};
        per_oe  = {48'h0, 16'hFFFF};
        per_out = {48'h0, 16'hFFFF};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9: first edge settles, reports nothing although pins read all ones
        @(posedge clk);
        #1;
        check("R9 settle change_vec", {16'h0, change_vec}, 32'h0);
        check("R9 settle slot_notify", {28'h0, slot_notify}, 32'h0);
        @(posedge clk);
        #1;
        check("R9 steady slot_notify", {28'h0, slot_notify}, 32'h0);
        bus_sel = 1'b0;
        #1;
        check("R1 ctrl after reset", bus_rdata, 32'h0);

        // R8: peripheral releases the pins, change reported
        @(negedge clk);
        per_oe = '0;
        per_out = '0;
        #1;
        check("R1 idle pin level", {16'h0, pin_level}, 32'h0);
        expect_change("R8 release", 16'hFFFF, 16'h0000);

        // R2 R3 R4: exhaustive truth table on every pin
        for (int n = 0; n < 16; n++) begin
            for (int k = 0; k < 32; k++) begin
                @(negedge clk);
                per_oe  = '0;
                per_out = '0;
                per_oe[16*(n%4)+n]  = k[2];
                per_out[16*(n%4)+n] = k[3];
                cw = '0;
                cw[2*n]   = k[0];
                cw[2*n+1] = k[4];
                dw = '0;
                dw[n] = k[1];
                wr(1'b0, cw);
                wr(1'b1, {16'h0, dw});
                exp = model(cw, dw, per_out, per_oe);
                #1;
                check("R3 pin level", {16'h0, pin_level}, {16'h0, exp});
                bus_sel = 1'b1;
                #1;
                check("R4 data read", bus_rdata, {16'h0, exp});
                bus_sel = 1'b0;
                #1;
                check("R2 ctrl read", bus_rdata, cw);
            end
        end

        // R5 R6 R7: notification by register writes
        @(negedge clk);
        per_oe = '0;
        per_out = '0;
        wr(1'b1, 32'h0);
        wr(1'b0, 32'h5555_5555);
        repeat (3) @(posedge clk);
        prev = 16'h0000;
        wr(1'b1, 32'h0003);
        expect_change("R7 data 0003", prev, 16'h0003);
        prev = 16'h0003;
        wr(1'b1, 32'h0003);
        @(posedge clk);
        #1;
        check("R6 same write change_vec", {16'h0, change_vec}, 32'h0);
        check("R6 same write slot_notify", {28'h0, slot_notify}, 32'h0);
        wr(1'b1, 32'h8103);
        expect_change("R5 data 8103", prev, 16'h8103);
        prev = 16'h8103;
        wr(1'b1, 32'h0010);
        expect_change("R7 data 0010", prev, 16'h0010);
        prev = 16'h0010;
        // control write: pins 4 turns input with pull-up on -> stays 1; others drop
        wr(1'b0, 32'h0000_0200);
        expect_change("R5 ctrl write", prev, 16'h0010);
        prev = 16'h0010;
        wr(1'b0, 32'h0000_0000);
        expect_change("R5 pullup off", prev, 16'h0000);
        prev = 16'h0000;

        // R8: peripheral slot 1 drives pin 12
        @(negedge clk);
        per_oe[16+12]  = 1'b1;
        per_out[16+12] = 1'b1;
        expect_change("R8 periph drive", prev, 16'h1000);
        @(negedge clk);
        per_out[16+12] = 1'b0;
        expect_change("R8 periph low", 16'h1000, 16'h0000);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule